// File: doc/BRIEF.md
# Pulsed Emitter Measurement Sequencer

This block times the measurement cycles of a reflective proximity channel. Each pulse drives an emitter-enable output high for one integration window. The integrate output marks the same window. The block then holds the emitter off so that the on time is a programmed fraction of the pulse period. At the last clock of each window it takes one sample from a converter that sits outside the block. One measurement cycle is made of one pulse, or of a burst of 2, 4, 8 or 16 pulses whose samples are either summed or averaged. At the end of the cycle the block presents an 8-bit result with a one-clock strobe.

The window length is built from a base time unit of `T_BASE` clocks. A bank field scales that unit and an integration field stretches it. Cycles either follow one another without a gap (continuous mode), or run one at a time, each started by a host write to a self-clearing trigger bit (forced mode). A shutdown input halts everything at once. A saturation input signals strong background light. While it is high, the reported result is replaced by a full-scale or zero code, and its rising and falling edges are reported as one-clock events.

The configuration is latched when a cycle starts. A change therefore takes effect from the next cycle.

Top module: `pulse_meas_seq`

## Requirements
- R1: While reset is high and on the first clock after it, `emit_en`, `integ_win`, `res_valid`, `trig_bit`, `sat_enter` and `sat_leave` are all 0.
- R2: The window length is W = round(T_BASE × B × I) clocks, where halves are rounded up. B is 0.5, 1, 2 or 4 for `cfg_bank` codes 0, 1, 2 and 3. I is 1.0, 1.3, 1.6 or 2.0 for `cfg_itime` codes 0, 1, 2 and 3. `emit_en` stays high for exactly W clocks per pulse.
- R3: The period between successive rising edges of `emit_en` is W × R clocks, where R is 5120, 640, 80 or 20 for `cfg_duty` codes 0, 1, 2 and 3. The rule also holds across cycle boundaries in continuous mode. `integ_win` is high in exactly the clocks where `emit_en` is high.
- R4: A cycle has N = 2^(`cfg_count_sel`+1) pulses when `cfg_avg_en` or `cfg_multi` is 1, and one pulse otherwise.
- R5: With `cfg_avg_en` = 1, the result is the sum of the N samples shifted right by `cfg_count_sel`+1.
- R6: With `cfg_avg_en` = 0, the result is the sum of the samples, clipped to 255. Each sample is the value of `smp_data` at the last clock of its window.
- R7: `res_valid` is high for exactly one clock. That clock is the first clock after the last window of the cycle.
- R8: With `cfg_force` = 1, no pulse starts until `trig_wr` sets `trig_bit`. Each trigger then runs exactly one cycle, and `trig_bit` returns to 0 when that cycle ends.
- R9: A `trig_wr` that arrives while a cycle is running starts no further cycle. It is cleared when the running cycle ends.
- R10: `cfg_shutdown` = 1 drops `emit_en` on the next clock, aborts the cycle without a result and prevents new cycles.
- R11: If `sat_in` is 1 at the final sample of a cycle, the result is 0xFF when `cfg_sat_hi` = 1 and 0x00 when `cfg_sat_hi` = 0.
- R12: A 0-to-1 change of `sat_in` gives a one-clock `sat_enter`, and a 1-to-0 change gives a one-clock `sat_leave`. Each event appears on the clock after the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_shutdown | input | 1 | Halt and abort all cycles |
| cfg_force | input | 1 | One cycle per trigger instead of continuous |
| cfg_duty | input | 2 | Emitter on/off ratio code |
| cfg_itime | input | 2 | Integration stretch code |
| cfg_bank | input | 2 | Base-unit scale code |
| cfg_avg_en | input | 1 | Average the pulses of a cycle |
| cfg_multi | input | 1 | Multi-pulse cycle without averaging |
| cfg_count_sel | input | 2 | Pulse count select (2, 4, 8, 16) |
| cfg_sat_hi | input | 1 | Saturation result: 1 gives 0xFF, 0 gives 0x00 |
| trig_wr | input | 1 | Host writes 1 to the trigger bit |
| smp_data | input | 8 | Converter sample for the current pulse |
| sat_in | input | 1 | Background saturation detected |
| emit_en | output | 1 | Emitter enable |
| integ_win | output | 1 | Integration window |
| res_valid | output | 1 | One-clock result strobe |
| res_data | output | 8 | Measurement result |
| trig_bit | output | 1 | Pending trigger bit, readable by the host |
| sat_enter | output | 1 | One-clock event on entering saturation |
| sat_leave | output | 1 | One-clock event on leaving saturation |

## Verification
A wrong phase counter shows up on the first pulse. Either the high time of `emit_en` deviates from W, or the next rising edge arrives early or late, so the bench measures both on every pulse. A corrupted pulse index or accumulator stays hidden until the end of the cycle. It appears there as a wrong result or as a strobe after the wrong number of pulses, which takes up to 16 pulse periods to show. A stuck trigger bit shows up in forced mode as either a missing cycle or an extra one within one cycle period of the trigger.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_OFF  = 2'd2
  } pms_state_t;

  // period / on-time for each duty code
  function automatic int unsigned ratio_of(input logic [1:0] code);
    case (code)
      2'd0:    return 32'd5120;
      2'd1:    return 32'd640;
      2'd2:    return 32'd80;
      default: return 32'd20;
    endcase
  endfunction

  // bank scale expressed in half base units
  function automatic int unsigned bank_halves(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // integration stretch expressed in tenths
  function automatic int unsigned itime_tenths(input logic [1:0] code);
    case (code)
      2'd0:    return 32'd10;
      2'd1:    return 32'd13;
      2'd2:    return 32'd16;
      default: return 32'd20;
    endcase
  endfunction

endpackage

// File: rtl/pms_window.sv
module pms_window
  import pms_pkg::*;
#(
  parameter int T_BASE = 4,
  parameter int WIN_W  = 7,
  parameter int PER_W  = 19
) (
  input  logic [1:0]       duty,
  input  logic [1:0]       itime,
  input  logic [1:0]       bank,
  output logic [WIN_W-1:0] win_len,
  output logic [PER_W-1:0] off_len
);

  always_comb begin
    int unsigned w;
    int unsigned r;
    // T * (halves/2) * (tenths/10), rounded half up
    w = (T_BASE * bank_halves(bank) * itime_tenths(itime) + 32'd10) / 32'd20;
    r = ratio_of(duty);
    win_len = WIN_W'(w);
    off_len = PER_W'(w * (r - 32'd1));
  end

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
#(
  parameter int WIN_W = 7,
  parameter int PER_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shutdown,
  input  logic             force_mode,
  input  logic             trig_wr,
  input  logic             avg_en,
  input  logic             multi,
  input  logic [1:0]       count_sel,
  input  logic [WIN_W-1:0] win_len,
  input  logic [PER_W-1:0] off_len,
  output logic             emit_en,
  output logic             integ_win,
  output logic             cyc_start,
  output logic             smp_take,
  output logic             smp_last,
  output logic             trig_bit,
  output logic             avg_en_l,
  output logic [2:0]       shift_l
);

  pms_state_t       st;
  logic [PER_W-1:0] cnt;
  logic [3:0]       pidx;
  logic [3:0]       last_idx;
  logic [WIN_W-1:0] win_l;
  logic [PER_W-1:0] off_l;
  logic             trig_q;

  logic go_idle, at_end, last_p, cyc_done;

  always_comb begin
    go_idle   = !shutdown && (!force_mode || trig_q);
    at_end    = (cnt == '0);
    last_p    = (pidx == last_idx);
    cyc_done  = (st == ST_OFF) && at_end && last_p;
    cyc_start = !shutdown && (((st == ST_IDLE) && go_idle) || (cyc_done && !force_mode));
    smp_take  = !shutdown && (st == ST_ON) && at_end;
    smp_last  = smp_take && last_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      pidx     <= '0;
      last_idx <= '0;
      win_l    <= '0;
      off_l    <= '0;
      trig_q   <= 1'b0;
      avg_en_l <= 1'b0;
      shift_l  <= '0;
    end else begin
      if (cyc_done)     trig_q <= 1'b0;
      else if (trig_wr) trig_q <= 1'b1;

      if (shutdown) begin
        st   <= ST_IDLE;
        cnt  <= '0;
        pidx <= '0;
      end else if (cyc_start) begin
        st       <= ST_ON;
        cnt      <= PER_W'(win_len) - PER_W'(1);
        pidx     <= '0;
        win_l    <= win_len;
        off_l    <= off_len;
        last_idx <= (avg_en || multi) ? 4'((32'd2 << count_sel) - 32'd1) : 4'd0;
        avg_en_l <= avg_en;
        shift_l  <= 3'(count_sel) + 3'd1;
      end else begin
        case (st)
          ST_ON: begin
            if (at_end) begin
              st  <= ST_OFF;
              cnt <= off_l - PER_W'(1);
            end else begin
              cnt <= cnt - PER_W'(1);
            end
          end
          ST_OFF: begin
            if (at_end) begin
              if (last_p) begin
                st <= ST_IDLE;
              end else begin
                st   <= ST_ON;
                cnt  <= PER_W'(win_l) - PER_W'(1);
                pidx <= pidx + 4'd1;
              end
            end else begin
              cnt <= cnt - PER_W'(1);
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign emit_en   = (st == ST_ON);
  assign integ_win = (st == ST_ON);
  assign trig_bit  = trig_q;

  // R10: shutdown removes the emitter on the next clock
  p_shutdown_stops_r10: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> !emit_en);

  // R8: forced mode without a pending trigger stays idle
  p_force_waits_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && force_mode && !trig_q) |=> (st == ST_IDLE));

  // R2: the window counter never exceeds the latched window length
  p_cnt_in_window_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ON) |-> (PER_W'(win_l) > cnt));

  // R9: the trigger bit never drops while a cycle is still in flight
  p_trig_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (trig_q && st == ST_ON && !shutdown) |=> trig_q);

endmodule

// File: rtl/pms_accum.sv
module pms_accum #(
  parameter int DW = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          take,
  input  logic          last,
  input  logic [DW-1:0] din,
  input  logic          avg_en,
  input  logic [2:0]    shift,
  input  logic          sat,
  input  logic          sat_hi,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum_next;
  logic [AW-1:0] scaled;
  logic [DW-1:0] res_next;

  always_comb begin
    sum_next = acc + AW'(din);
    scaled   = avg_en ? (sum_next >> shift) : sum_next;
    if (sat)
      res_next = sat_hi ? {DW{1'b1}} : {DW{1'b0}};
    else if (|scaled[AW-1:DW])
      res_next = {DW{1'b1}};
    else
      res_next = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= take && last;
      if (clr)
        acc <= '0;
      else if (take)
        acc <= last ? '0 : sum_next;
      if (take && last)
        res_data <= res_next;
    end
  end

  // R7: the strobe lasts one clock
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R11: saturation with the high override yields full scale
  p_sat_full_r11: assert property (@(posedge clk) disable iff (rst)
    (take && last && sat && sat_hi) |=> (res_data == {DW{1'b1}}));

  // R11: saturation with the low override yields zero
  p_sat_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (take && last && sat && !sat_hi) |=> (res_data == {DW{1'b0}}));

endmodule

// File: rtl/pulse_meas_seq.sv
module pulse_meas_seq #(
  parameter int T_BASE = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_shutdown,
  input  logic              cfg_force,
  input  logic [1:0]        cfg_duty,
  input  logic [1:0]        cfg_itime,
  input  logic [1:0]        cfg_bank,
  input  logic              cfg_avg_en,
  input  logic              cfg_multi,
  input  logic [1:0]        cfg_count_sel,
  input  logic              cfg_sat_hi,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              sat_in,
  output logic              emit_en,
  output logic              integ_win,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              trig_bit,
  output logic              sat_enter,
  output logic              sat_leave
);

  localparam int WIN_MAX = 16 * T_BASE;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int PER_W   = $clog2(WIN_MAX * 5120 + 1);

  logic [WIN_W-1:0] win_len;
  logic [PER_W-1:0] off_len;
  logic             cyc_start, smp_take, smp_last, avg_en_l;
  logic [2:0]       shift_l;
  logic             sat_q;

  pms_window #(.T_BASE(T_BASE), .WIN_W(WIN_W), .PER_W(PER_W)) u_window (
    .duty    (cfg_duty),
    .itime   (cfg_itime),
    .bank    (cfg_bank),
    .win_len (win_len),
    .off_len (off_len)
  );

  pms_ctrl #(.WIN_W(WIN_W), .PER_W(PER_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shutdown   (cfg_shutdown),
    .force_mode (cfg_force),
    .trig_wr    (trig_wr),
    .avg_en     (cfg_avg_en),
    .multi      (cfg_multi),
    .count_sel  (cfg_count_sel),
    .win_len    (win_len),
    .off_len    (off_len),
    .emit_en    (emit_en),
    .integ_win  (integ_win),
    .cyc_start  (cyc_start),
    .smp_take   (smp_take),
    .smp_last   (smp_last),
    .trig_bit   (trig_bit),
    .avg_en_l   (avg_en_l),
    .shift_l    (shift_l)
  );

  pms_accum #(.DW(DATA_W), .AW(ACC_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clr       (cyc_start),
    .take      (smp_take),
    .last      (smp_last),
    .din       (smp_data),
    .avg_en    (avg_en_l),
    .shift     (shift_l),
    .sat       (sat_in),
    .sat_hi    (cfg_sat_hi),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_q     <= 1'b0;
      sat_enter <= 1'b0;
      sat_leave <= 1'b0;
    end else begin
      sat_q     <= sat_in;
      sat_enter <= sat_in && !sat_q;
      sat_leave <= !sat_in && sat_q;
    end
  end

  // R12: a rising saturation input is reported on the next clock
  p_sat_enter_r12: assert property (@(posedge clk) disable iff (rst)
    ($rose(sat_in) && !$past(rst)) |=> sat_enter);

  // R12: the events are single-clock pulses
  p_sat_event_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (sat_enter || sat_leave) |=> !(sat_enter || sat_leave));

endmodule

// File: tb/pulse_meas_seq_bench.sv
module pulse_meas_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_shutdown = 1'b1, cfg_force = 1'b0, cfg_avg_en = 1'b0, cfg_multi = 1'b0;
  logic [1:0] cfg_duty = 2'd0, cfg_itime = 2'd0, cfg_bank = 2'd0, cfg_count_sel = 2'd0;
  logic       cfg_sat_hi = 1'b0, trig_wr = 1'b0, sat_in = 1'b0;
  logic [7:0] smp_data = 8'd0;
  logic       emit_en, integ_win, res_valid, trig_bit, sat_enter, sat_leave;
  logic [7:0] res_data;

  always #2 clk = ~clk;

  pulse_meas_seq u_pulse_meas_seq (
    .clk(clk), .rst(rst), .cfg_shutdown(cfg_shutdown), .cfg_force(cfg_force),
    .cfg_duty(cfg_duty), .cfg_itime(cfg_itime), .cfg_bank(cfg_bank),
    .cfg_avg_en(cfg_avg_en), .cfg_multi(cfg_multi), .cfg_count_sel(cfg_count_sel),
    .cfg_sat_hi(cfg_sat_hi), .trig_wr(trig_wr), .smp_data(smp_data), .sat_in(sat_in),
    .emit_en(emit_en), .integ_win(integ_win), .res_valid(res_valid), .res_data(res_data),
    .trig_bit(trig_bit), .sat_enter(sat_enter), .sat_leave(sat_leave)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int cyc = 0, rises, falls, last_rise, period, high_len, run_len, nres;
  int first_res, last_res, rises_at_res1, rv_bad, rv_at_fall, n_enter, n_leave, ie_mis;
  int pidx, seed = 0, step = 0;
  bit e_prev, i_prev;

  function automatic logic [7:0] smp_of(input int k);
    return 8'(seed + step * k);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      if (emit_en !== integ_win) ie_mis++;
      if (emit_en && !e_prev) begin
        if (rises > 0) period = cyc - last_rise;
        last_rise = cyc;
        rises++;
      end
      if (emit_en) run_len++;
      else if (e_prev) begin
        high_len = run_len; run_len = 0; falls++;
        if (res_valid) rv_at_fall++;
      end
      if (res_valid) begin
        if (emit_en || !e_prev) rv_bad++;
        if (nres == 0) begin first_res = res_data; rises_at_res1 = rises; end
        last_res = res_data;
        nres++;
      end
      if (sat_enter) n_enter++;
      if (sat_leave) n_leave++;
      if (!integ_win && i_prev) begin pidx++; smp_data = smp_of(pidx); end
      e_prev = emit_en; i_prev = integ_win;
    end
  endtask

  task automatic clear_mon();
    rises = 0; falls = 0; last_rise = 0; period = 0; high_len = 0; run_len = 0;
    nres = 0; first_res = -1; last_res = -1; rises_at_res1 = 0; rv_bad = 0;
    rv_at_fall = 0; n_enter = 0; n_leave = 0; ie_mis = 0; pidx = 0;
    smp_data = smp_of(0); e_prev = 0; i_prev = 0;
  endtask

  task automatic restart(input logic [1:0] d, input logic [1:0] it, input logic [1:0] bk,
                         input logic av, input logic mp, input logic [1:0] sel, input logic fm);
    cfg_shutdown = 1'b1;
    run(2);
    cfg_duty = d; cfg_itime = it; cfg_bank = bk; cfg_avg_en = av;
    cfg_multi = mp; cfg_count_sel = sel; cfg_force = fm;
    clear_mon();
    cfg_shutdown = 1'b0;
  endtask

  task automatic t_reset();
    clear_mon();
    run(3);
    chk("R1 emit_en in reset", emit_en, 0);
    chk("R1 integ_win in reset", integ_win, 0);
    chk("R1 res_valid in reset", res_valid, 0);
    chk("R1 trig_bit in reset", trig_bit, 0);
    rst = 1'b0;
    run(1);
    chk("R1 emit_en after reset", emit_en, 0);
    chk("R1 sat events after reset", sat_enter + sat_leave, 0);
  endtask

  task automatic t_window(input logic [1:0] bk, input logic [1:0] it, input int w_exp);
    seed = 10; step = 1;
    restart(2'd3, it, bk, 1'b0, 1'b0, 2'd0, 1'b0);
    run(3 * w_exp * 20 + 5);
    chk($sformatf("R2 window bank%0d it%0d", bk, it), high_len, w_exp);
    chk($sformatf("R3 period bank%0d it%0d", bk, it), period, w_exp * 20);
    chk("R3 integ_win matches emit_en", ie_mis, 0);
  endtask

  task automatic t_duty(input logic [1:0] d, input int ratio);
    restart(d, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    run(2 * 2 * ratio + 10);
    chk($sformatf("R3 period duty%0d", d), period, 2 * ratio);
    chk($sformatf("R3 pulses duty%0d", d), rises, 3);
  endtask

  task automatic t_single();
    seed = 57; step = 5;
    restart(2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    run(130);
    chk("R6 single-pulse result", first_res, 57);
    chk("R6 later result follows sample", last_res, 72);
    chk("R7 strobe aligned to window end", rv_bad, 0);
    chk("R7 one strobe per pulse", rv_at_fall, falls);
    chk("R4 single pulse per result", rises_at_res1, 1);
  endtask

  task automatic t_avg(input logic [1:0] sel);
    int n, sum;
    n = 2 << sel;
    seed = 40; step = 23;
    restart(2'd3, 2'd0, 2'd0, 1'b1, 1'b0, sel, 1'b0);
    run(n * 40 + 20);
    sum = 0;
    for (int k = 0; k < n; k++) sum += int'(smp_of(k));
    chk($sformatf("R5 mean of %0d pulses", n), first_res, sum / n);
    chk($sformatf("R4 pulses before result (%0d)", n), rises_at_res1, n);
    chk("R7 strobe at last window end", rv_bad, 0);
  endtask

  task automatic t_multi();
    seed = 200; step = 23;
    restart(2'd3, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0);
    run(100);
    chk("R6 summed result clipped", first_res, 255);
    chk("R4 multi pulse count", rises_at_res1, 2);
  endtask

  task automatic t_force();
    seed = 33; step = 0;
    restart(2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
    run(100);
    chk("R8 no pulse without trigger", rises, 0);
    trig_wr = 1'b1; run(1); trig_wr = 1'b0;
    chk("R8 trigger bit set", trig_bit, 1);
    run(10);
    trig_wr = 1'b1; run(1); trig_wr = 1'b0;
    chk("R9 bit held during cycle", trig_bit, 1);
    run(200);
    chk("R8 exactly one pulse", rises, 1);
    chk("R8 exactly one result", nres, 1);
    chk("R8 result value", first_res, 33);
    chk("R8 trigger bit self-clears", trig_bit, 0);
    chk("R9 mid-cycle trigger ignored", falls, 1);
  endtask

  task automatic t_shutdown();
    seed = 5; step = 0;
    restart(2'd3, 2'd0, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0);
    for (int k = 0; k < 50 && !emit_en; k++) run(1);
    run(2);
    cfg_shutdown = 1'b1;
    run(1);
    chk("R10 emitter drops next clock", emit_en, 0);
    clear_mon();
    run(300);
    chk("R10 no pulses in shutdown", rises, 0);
    chk("R10 no result in shutdown", nres, 0);
  endtask

  task automatic t_sat();
    seed = 57; step = 0;
    cfg_sat_hi = 1'b1;
    restart(2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    sat_in = 1'b1;
    run(100);
    chk("R11 high override", first_res, 255);
    chk("R12 one enter event", n_enter, 1);
    chk("R12 no leave event yet", n_leave, 0);
    cfg_sat_hi = 1'b0;
    run(45);
    chk("R11 low override", last_res, 0);
    sat_in = 1'b0;
    run(50);
    chk("R12 one leave event", n_leave, 1);
    chk("R11 normal result after leaving", last_res, 57);
    chk("R12 enter count unchanged", n_enter, 1);
  endtask

  initial begin
    t_reset();
    t_window(2'd1, 2'd0, 4);
    t_window(2'd0, 2'd1, 3);
    t_window(2'd0, 2'd2, 3);
    t_window(2'd3, 2'd1, 21);
    t_window(2'd2, 2'd3, 16);
    t_duty(2'd2, 80);
    t_duty(2'd1, 640);
    t_duty(2'd0, 5120);
    t_single();
    t_avg(2'd1);
    t_avg(2'd2);
    t_multi();
    t_force();
    t_shutdown();
    t_sat();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule